// File: doc/BRIEF.md
# Three-Stage Pipelined Sum-Difference-Scale Datapath

This block is a fully pipelined arithmetic datapath. It accepts four unsigned operands on every clock cycle and returns one result per cycle, each result appearing a fixed three cycles after its operands were presented. The first stage forms the sum of the first two operands and, alongside it, the difference of the third and fourth. The second stage adds those two intermediate values. The third stage multiplies that combined value by the fourth operand.

The fourth operand is used twice, in stage one and again in stage three. A delay register in each stage carries it forward, so the multiply always uses the copy that belongs to the same input sample. A valid flag moves through the same stages as the data and marks which output cycles carry real results. Every intermediate value is widened so that nothing is truncated. The result is a two's complement number wide enough for any combination of inputs.

Top module: `arith_pipe3`

## Requirements
- R1: While `rst` is sampled high at a rising edge, every pipeline register is cleared. From the following cycle on, `res_vld` reads 0 and `res` reads 0 for as long as reset is held.
- R2: `res_vld` is high in cycle t+3 exactly when `op_vld` was high in cycle t and no reset edge came in between. It is low in every other cycle.
- R3: A valid result equals ((a + b) + (c - d)) * d. The operands are unsigned N-bit values and the result is a two's complement number of 2N+4 bits, with no truncation at any stage.
- R4: The multiplier in stage three uses the `op_d` value of the same input sample as the value it scales, even when `op_d` changes every cycle.
- R5: Back-to-back valid inputs give back-to-back valid results, in input order, one per cycle.
- R6: When c - d is negative, the combined value and the result carry the correct sign. The smallest case is a = b = c = 0 with d at its maximum, which gives -(2^N-1)^2.
- R7: All operands at their maximum value (2^N-1) give a correct, untruncated positive result.
- R8: Gaps in `op_vld` show up at the same positions in `res_vld`, three cycles later.
- R9: A reset asserted while samples are in flight discards them. None of them appears on the output after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Marks the current operand set as valid |
| op_a | input | N | First addend, unsigned |
| op_b | input | N | Second addend, unsigned |
| op_c | input | N | Minuend, unsigned |
| op_d | input | N | Subtrahend and multiplier, unsigned |
| res_vld | output | 1 | Marks `res` as a valid result |
| res | output | 2N+4 | Two's complement result |

## Verification
Small directed values confirm the basic formula. A case with c below d checks that sign extension is handled through stage two and into the signed multiply. The all-ones and all-zero-but-d corners test the largest positive and largest negative results, which would expose any stage that was sized too narrow. A burst of random operands with `op_d` changing every cycle shows whether the delayed copy of d stays in step with its sample. Any skew would pair a product with a neighbour's d. Sparse valid patterns and a reset in the middle of a burst check that the valid flag keeps the right gap positions and that in-flight work is dropped.

// File: rtl/arith_pkg.sv
package arith_pkg;

  parameter int unsigned DEF_OPW = 16;

  // unsigned sum of two N-bit values
  function automatic int unsigned sum_w(input int unsigned n);
    return n + 1;
  endfunction

  // signed combination of sum and difference
  function automatic int unsigned comb_w(input int unsigned n);
    return n + 3;
  endfunction

  // signed product of the combined value and zero-extended d
  function automatic int unsigned prod_w(input int unsigned n);
    return comb_w(n) + n + 1;
  endfunction

endpackage

// File: rtl/arith_sum_diff.sv
module arith_sum_diff #(
  parameter int unsigned N = arith_pkg::DEF_OPW
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_vld,
  input  logic [N-1:0]                a,
  input  logic [N-1:0]                b,
  input  logic [N-1:0]                c,
  input  logic [N-1:0]                d,
  output logic                        out_vld,
  output logic [arith_pkg::sum_w(N)-1:0] sum_q,
  output logic signed [arith_pkg::sum_w(N)-1:0] diff_q,
  output logic [N-1:0]                d_q
);
  localparam int unsigned SW = arith_pkg::sum_w(N);

  function automatic logic [SW-1:0] add_u(input logic [N-1:0] x, input logic [N-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic signed [SW-1:0] sub_s(input logic [N-1:0] x, input logic [N-1:0] y);
    return $signed({1'b0, x}) - $signed({1'b0, y});
  endfunction

  logic [SW-1:0]        sum_d;
  logic signed [SW-1:0] diff_d;

  always_comb begin
    sum_d  = add_u(a, b);
    diff_d = sub_s(c, d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      sum_q   <= '0;
      diff_q  <= '0;
      d_q     <= '0;
    end else begin
      out_vld <= in_vld;
      sum_q   <= sum_d;
      diff_q  <= diff_d;
      d_q     <= d;
    end
  end
endmodule

// File: rtl/arith_merge.sv
module arith_merge #(
  parameter int unsigned N = arith_pkg::DEF_OPW
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   in_vld,
  input  logic [arith_pkg::sum_w(N)-1:0]         sum_i,
  input  logic signed [arith_pkg::sum_w(N)-1:0]  diff_i,
  input  logic [N-1:0]                           d_i,
  output logic                                   out_vld,
  output logic signed [arith_pkg::comb_w(N)-1:0] comb_q,
  output logic [N-1:0]                           d_q
);
  localparam int unsigned SW = arith_pkg::sum_w(N);
  localparam int unsigned YW = arith_pkg::comb_w(N);

  function automatic logic signed [YW-1:0] merge(input logic [SW-1:0] s,
                                                 input logic signed [SW-1:0] df);
    logic signed [YW-1:0] se;
    logic signed [YW-1:0] de;
    se = $signed(YW'(s));
    de = YW'(df);
    return se + de;
  endfunction

  logic signed [YW-1:0] comb_d;

  always_comb comb_d = merge(sum_i, diff_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      comb_q  <= '0;
      d_q     <= '0;
    end else begin
      out_vld <= in_vld;
      comb_q  <= comb_d;
      d_q     <= d_i;
    end
  end
endmodule

// File: rtl/arith_scale.sv
module arith_scale #(
  parameter int unsigned N = arith_pkg::DEF_OPW
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   in_vld,
  input  logic signed [arith_pkg::comb_w(N)-1:0] comb_i,
  input  logic [N-1:0]                           d_i,
  output logic                                   out_vld,
  output logic signed [arith_pkg::prod_w(N)-1:0] prod_q
);
  localparam int unsigned YW = arith_pkg::comb_w(N);
  localparam int unsigned ZW = arith_pkg::prod_w(N);

  function automatic logic signed [ZW-1:0] scale(input logic signed [YW-1:0] y,
                                                 input logic [N-1:0] m);
    logic signed [ZW-1:0] ye;
    logic signed [ZW-1:0] me;
    ye = ZW'(y);
    me = ZW'($signed({1'b0, m}));
    return ye * me;
  endfunction

  logic signed [ZW-1:0] prod_d;

  always_comb prod_d = scale(comb_i, d_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      prod_q  <= '0;
    end else begin
      out_vld <= in_vld;
      prod_q  <= prod_d;
    end
  end
endmodule

// File: rtl/arith_pipe3.sv
module arith_pipe3 #(
  parameter int unsigned N = arith_pkg::DEF_OPW
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                op_vld,
  input  logic [N-1:0]                        op_a,
  input  logic [N-1:0]                        op_b,
  input  logic [N-1:0]                        op_c,
  input  logic [N-1:0]                        op_d,
  output logic                                res_vld,
  output logic [arith_pkg::prod_w(N)-1:0]     res
);
  localparam int unsigned SW = arith_pkg::sum_w(N);
  localparam int unsigned YW = arith_pkg::comb_w(N);
  localparam int unsigned ZW = arith_pkg::prod_w(N);

  // named stage boundaries, also observed by the checker
  logic                 st1_vld;
  logic [SW-1:0]        st1_sum;
  logic signed [SW-1:0] st1_diff;
  logic [N-1:0]         st1_d;
  logic                 st2_vld;
  logic signed [YW-1:0] st2_comb;
  logic [N-1:0]         st2_d;
  logic signed [ZW-1:0] st3_prod;

  arith_sum_diff #(.N(N)) u_s1 (
    .clk(clk), .rst(rst), .in_vld(op_vld),
    .a(op_a), .b(op_b), .c(op_c), .d(op_d),
    .out_vld(st1_vld), .sum_q(st1_sum), .diff_q(st1_diff), .d_q(st1_d)
  );

  arith_merge #(.N(N)) u_s2 (
    .clk(clk), .rst(rst), .in_vld(st1_vld),
    .sum_i(st1_sum), .diff_i(st1_diff), .d_i(st1_d),
    .out_vld(st2_vld), .comb_q(st2_comb), .d_q(st2_d)
  );

  arith_scale #(.N(N)) u_s3 (
    .clk(clk), .rst(rst), .in_vld(st2_vld),
    .comb_i(st2_comb), .d_i(st2_d),
    .out_vld(res_vld), .prod_q(st3_prod)
  );

  assign res = st3_prod;
endmodule

// File: rtl/arith_pipe3_checker.sv
module arith_pipe3_checker #(
  parameter int unsigned N = arith_pkg::DEF_OPW
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            op_vld,
  input logic [N-1:0]                    op_a,
  input logic [N-1:0]                    op_b,
  input logic [N-1:0]                    op_c,
  input logic [N-1:0]                    op_d,
  input logic                            st1_vld,
  input logic                            st2_vld,
  input logic [N-1:0]                    st2_d,
  input logic                            res_vld,
  input logic [arith_pkg::prod_w(N)-1:0] res
);
  localparam int unsigned YW = arith_pkg::comb_w(N);
  localparam int unsigned ZW = arith_pkg::prod_w(N);

  // operand history, independent of the datapath
  logic [N-1:0] ha [3];
  logic [N-1:0] hb [3];
  logic [N-1:0] hc [3];
  logic [N-1:0] hd [3];

  always_ff @(posedge clk) begin
    ha[0] <= op_a; hb[0] <= op_b; hc[0] <= op_c; hd[0] <= op_d;
    for (int i = 1; i < 3; i++) begin
      ha[i] <= ha[i-1]; hb[i] <= hb[i-1]; hc[i] <= hc[i-1]; hd[i] <= hd[i-1];
    end
  end

  logic signed [YW-1:0] ref_y;
  logic signed [ZW-1:0] ref_z;
  always_comb begin
    ref_y = $signed(YW'(ha[2])) + $signed(YW'(hb[2])) + $signed(YW'(hc[2]))
          - $signed(YW'(hd[2]));
    ref_z = ZW'(ref_y) * $signed(ZW'(hd[2]));
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!res_vld && res == '0));

  assert_vld_enter_R2: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> st1_vld);

  assert_vld_gap_R8: assert property (@(posedge clk) disable iff (rst)
    !op_vld |=> !st1_vld);

  assert_vld_mid_R5: assert property (@(posedge clk) disable iff (rst)
    st1_vld |=> st2_vld);

  assert_vld_out_R2: assert property (@(posedge clk) disable iff (rst)
    st2_vld |=> res_vld);

  assert_vld_out_gap_R8: assert property (@(posedge clk) disable iff (rst)
    !st2_vld |=> !res_vld);

  assert_d_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    st2_vld |-> st2_d == hd[1]);

  assert_result_R3: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> res == ref_z);
endmodule

bind arith_pipe3 arith_pipe3_checker #(.N(N)) chk (
  .clk(clk), .rst(rst), .op_vld(op_vld),
  .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
  .st1_vld(st1_vld), .st2_vld(st2_vld), .st2_d(st2_d),
  .res_vld(res_vld), .res(res)
);

// File: tb/arith_pipe3_test.sv
module arith_pipe3_test;
  localparam int unsigned N  = 16;
  localparam int unsigned ZW = arith_pkg::prod_w(N);
  localparam int unsigned MAXV = (1 << N) - 1;

  typedef struct {
    logic [ZW-1:0] exp;
    int            cyc;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_vld = 1'b0;
  logic [N-1:0]  op_a = '0, op_b = '0, op_c = '0, op_d = '0;
  logic          res_vld;
  logic [ZW-1:0] res;

  int    checks = 0;
  int    errors = 0;
  int    cycle  = 0;
  bit    done   = 1'b0;
  bit    mon_en = 1'b0;
  item_t sb[$];

  arith_pipe3 #(.N(N)) uut (
    .clk(clk), .rst(rst), .op_vld(op_vld),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
    .res_vld(res_vld), .res(res)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [ZW-1:0] model(input longint a, input longint b,
                                          input longint c, input longint d);
    longint t;
    t = (a + b + c - d) * d;
    return t[ZW-1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [ZW-1:0] act,
                       input logic [ZW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input int a, input int b, input int c, input int d, input string tag);
    item_t it;
    @(negedge clk);
    op_vld = 1'b1;
    op_a = N'(a); op_b = N'(b); op_c = N'(c); op_d = N'(d);
    it.exp = model(a, b, c, d);
    it.cyc = cycle + 3;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_vld = 1'b0;
      op_a = N'($urandom); op_d = N'($urandom);
    end
  endtask

  // monitor: compares results against the scoreboard
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (sb.size() != 0 && sb[0].cyc == cycle) begin
        item_t it;
        it = sb.pop_front();
        check(res_vld == 1'b1, {it.tag, " R2 valid latency"}, ZW'(res_vld), ZW'(1));
        check(res == it.exp, it.tag, res, it.exp);
      end else begin
        check(res_vld == 1'b0, "R2/R9 no stray valid", ZW'(res_vld), ZW'(0));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_vld == 1'b0, "R1 reset valid", ZW'(res_vld), ZW'(0));
    check(res == '0, "R1 reset result", res, '0);
    @(negedge clk);
    rst = 1'b0;
    mon_en = 1'b1;

    // R3 basic values
    send(1, 2, 3, 1, "R3 small");
    send(5, 7, 9, 2, "R3 small2");
    idle(1);
    // R6 negative difference and combined value
    send(0, 0, 0, 5, "R6 negative small");
    send(3, 0, 1, 10, "R6 negative mixed");
    send(0, 0, 0, MAXV, "R6 most negative");
    // R7 maximum operands
    send(MAXV, MAXV, MAXV, MAXV, "R7 all max");
    send(MAXV, MAXV, MAXV, 0, "R7 d zero");
    send(MAXV, MAXV, MAXV, 1, "R7 d one");
    idle(4);

    // R4/R5 back-to-back burst with d changing every cycle
    for (int i = 0; i < 40; i++)
      send($urandom & MAXV, $urandom & MAXV, $urandom & MAXV, (i * 977 + 13) & MAXV,
           "R4/R5 burst");
    idle(4);

    // R8 sparse valid pattern
    for (int i = 0; i < 24; i++) begin
      if ((i % 3) == 1 || (i % 5) == 0)
        send($urandom & MAXV, $urandom & MAXV, $urandom & MAXV, $urandom & MAXV,
             "R8 gaps");
      else
        idle(1);
    end
    idle(4);

    // R9 reset while samples are in flight
    send(11, 22, 33, 4, "R9 pre");
    send(12, 23, 34, 5, "R9 pre");
    @(negedge clk);
    mon_en = 1'b0;
    rst = 1'b1;
    op_vld = 1'b0;
    sb.delete();
    @(negedge clk);
    check(res_vld == 1'b0, "R9 flushed valid", ZW'(res_vld), ZW'(0));
    check(res == '0, "R1 mid reset result", res, '0);
    @(negedge clk);
    check(res_vld == 1'b0, "R1 held reset valid", ZW'(res_vld), ZW'(0));
    rst = 1'b0;
    mon_en = 1'b1;
    idle(5);
    send(2, 2, 2, 2, "R3 after reset");
    idle(5);

    check(sb.size() == 0, "R5 scoreboard drained", ZW'(sb.size()), '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule